// File: doc/BRIEF.md
# Coprocessor Error Latch Port

This block decodes a fixed window of sixteen I/O ports that a legacy math coprocessor once owned. It watches a simple I/O bus (address, write data, access size, write strobe, read strobe). It holds the coprocessor error interrupt as a level latch that an error input pin sets, and that software clears by writing a byte anywhere in the window.

Two ports carry commands. A byte write to the first port of the window clears the busy latch. A byte write to the second port resets the coprocessor. Each command gives a one-cycle event pulse on its own output, which the surrounding logic consumes. The block does not emulate the coprocessor datapath. It therefore reports every access it cannot serve on a one-cycle unsupported-access flag:

- writes to the opcode-transfer ports and to the other ports of the window,
- writes wider than a byte,
- reads.

All outputs are registered. An access sampled at one clock edge shows its effect on the outputs from that edge onward.

Top module: `cop_err_port`

## Requirements
- R1: The window covers I/O addresses 0x00F0 to 0x00FF. An access at any other address leaves every output unchanged and raises no pulse.
- R2: A byte write (size code 0) to 0x00F0 produces a one-cycle pulse on `clr_busy_evt` in the cycle after the write is sampled.
- R3: A byte write to 0x00F1 produces a one-cycle pulse on `cop_rst_evt` in the cycle after the write is sampled.
- R4: Any byte write inside the window drives `irq_err` low from the next cycle, unless R8 applies.
- R5: A byte write to any window port other than 0x00F0 and 0x00F1 pulses `unsup_acc` for one cycle. This includes the opcode-transfer ports 0x00F8, 0x00FA and 0x00FC.
- R6: A write inside the window with a size code other than 0 (1 = word, 2 = dword, 3 = reserved) pulses `unsup_acc`. It does not clear `irq_err` and produces no event pulse.
- R7: A rising edge on `err_in` sets `irq_err` one cycle later. Holding `err_in` high does not set the latch again after it has been cleared.
- R8: If an error rising edge and a clearing write occur in the same cycle, `irq_err` is set.
- R9: A read inside the window returns 0xFF on `rd_data` in the next cycle and pulses `unsup_acc`. Any other cycle shows 0x00 on `rd_data`.
- R10: While `rst_n` is low at a clock edge, `irq_err`, both event outputs, `unsup_acc` and `rd_data` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data (ignored by the commands) |
| io_size | input | 2 | Access size code: 0 byte, 1 word, 2 dword, 3 reserved |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| err_in | input | 1 | Coprocessor error pin, set on rising edge |
| rd_data | output | 8 | Read return value |
| irq_err | output | 1 | Level interrupt request for the coprocessor error |
| clr_busy_evt | output | 1 | Clear-busy command pulse |
| cop_rst_evt | output | 1 | Coprocessor reset command pulse |
| unsup_acc | output | 1 | Unsupported-access pulse |

## Verification
A stale edge-detect register would show up at once: `irq_err` would re-assert after a clear while `err_in` is still held high, or would miss a new rising edge. Either shows on the first cycle after the stimulus. A wrong decode of the window bounds or of the port offsets shows, in the cycle after the access, as a missing or extra event or unsupported pulse, or as an interrupt cleared by an access that should not clear it. Priority between set and clear is observable only in the one cycle where both occur, so the bench makes both happen on the same edge.

// File: rtl/cop_port_pkg.sv
// Package: shared types and constants for the coprocessor error latch port.
// Assumes a single-cycle I/O bus where each strobe marks exactly one access.
package cop_port_pkg;

    // Access size encoding on the I/O bus.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } io_size_e;

    // Port offsets inside the window that carry commands.
    localparam int unsigned OFF_CLR_BUSY = 0;
    localparam int unsigned OFF_COP_RST  = 1;

    // Decoded view of one bus cycle.
    typedef struct packed {
        logic hit;        // address falls in the window
        logic byte_wr;    // byte write inside the window
        logic clr_cmd;    // clear-busy command
        logic rst_cmd;    // coprocessor reset command
        logic unsup;      // access the block cannot serve
        logic rd_hit;     // read inside the window
    } dec_t;

endpackage

// File: rtl/cop_port_decode.sv
// Module: cop_port_decode
// Combinational address and size decode for the port window.
// Assumes BASE_ADDR is aligned to the window size (low WIN_BITS bits zero).
module cop_port_decode
    import cop_port_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 16,
    parameter int unsigned        WIN_BITS  = 4,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'h00F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr,
    input  logic              rd,
    output dec_t              dec
);
    localparam int unsigned TAG_W = ADDR_W - WIN_BITS;
    localparam int unsigned N_PORTS = 1 << WIN_BITS;

    logic [TAG_W-1:0]    tag;
    logic [WIN_BITS-1:0] off;
    logic [N_PORTS-1:0]  cmd_port;   // one-hot flags for ports with a command
    logic                is_byte;

    assign tag     = addr[ADDR_W-1:WIN_BITS];
    assign off     = addr[WIN_BITS-1:0];
    assign is_byte = (io_size_e'(size) == SZ_BYTE);

    // Mark which window offsets own a command; all others are unsupported.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_cmd_port
        assign cmd_port[p] = (p == OFF_CLR_BUSY) || (p == OFF_COP_RST);
    end

    // Build the decoded view of the current bus cycle.
    always_comb begin
        dec.hit     = (tag == BASE_ADDR[ADDR_W-1:WIN_BITS]);
        dec.byte_wr = dec.hit && wr && is_byte;
        dec.clr_cmd = dec.byte_wr && (off == WIN_BITS'(OFF_CLR_BUSY));
        dec.rst_cmd = dec.byte_wr && (off == WIN_BITS'(OFF_COP_RST));
        dec.rd_hit  = dec.hit && rd;
        dec.unsup   = (dec.hit && wr && !is_byte)
                    || (dec.byte_wr && !cmd_port[off])
                    || dec.rd_hit;
    end

endmodule

// File: rtl/cop_irq_latch.sv
// Module: cop_irq_latch
// Level interrupt latch: set on a rising edge of the error pin, cleared by
// a request; set has priority. Assumes err_in is already synchronous.
module cop_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic err_in,
    input  logic clr,
    output logic irq
);
    logic err_q;
    logic err_rise;

    assign err_rise = err_in && !err_q;

    // Remember the previous error pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_in;
    end

    // Hold the interrupt level; a new edge beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (err_rise) irq <= 1'b1;
        else if (clr)      irq <= 1'b0;
    end

endmodule

// File: rtl/cop_event_regs.sv
// Module: cop_event_regs
// Registers the one-cycle pulses and the read return value.
// Assumes the decode inputs are valid for exactly one cycle per access.
module cop_event_regs
    import cop_port_pkg::*;
#(
    parameter int unsigned      DATA_W   = 8,
    parameter logic [DATA_W-1:0] UNUSED_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    output logic              clr_evt,
    output logic              rst_evt,
    output logic              unsup,
    output logic [DATA_W-1:0] rd_data
);
    // Pulse outputs follow the decode by one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_evt <= 1'b0;
            rst_evt <= 1'b0;
            unsup   <= 1'b0;
        end else begin
            clr_evt <= dec.clr_cmd;
            rst_evt <= dec.rst_cmd;
            unsup   <= dec.unsup;
        end
    end

    // Present the unused-port value for one cycle after a window read.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_data <= '0;
        else if (dec.rd_hit) rd_data <= UNUSED_VAL;
        else                 rd_data <= '0;
    end

endmodule

// File: rtl/cop_err_port.sv
// Module: cop_err_port (top)
// Port-window decoder for the legacy coprocessor error interrupt.
// Assumes one access per strobe cycle and a synchronous error pin.
module cop_err_port
    import cop_port_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       WIN_BITS  = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [1:0]        io_size,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              err_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_err,
    output logic              clr_busy_evt,
    output logic              cop_rst_evt,
    output logic              unsup_acc
);
    dec_t dec;
    logic wdata_unused;

    // Command ports act on the address only; data is not interpreted.
    assign wdata_unused = ^io_wdata;

    cop_port_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(io_addr),
        .size(io_size),
        .wr  (io_wr),
        .rd  (io_rd),
        .dec (dec)
    );

    cop_irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .err_in(err_in),
        .clr   (dec.byte_wr),
        .irq   (irq_err)
    );

    cop_event_regs #(
        .DATA_W(DATA_W)
    ) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec    (dec),
        .clr_evt(clr_busy_evt),
        .rst_evt(cop_rst_evt),
        .unsup  (unsup_acc),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/cop_err_port_checker.sv
// Module: cop_err_port_checker
// Temporal checks on the top-level ports, attached by bind.
module cop_err_port_checker #(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       WIN_BITS  = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [1:0]        io_size,
    input logic              io_wr,
    input logic              io_rd,
    input logic              err_in,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_err,
    input logic              clr_busy_evt,
    input logic              cop_rst_evt,
    input logic              unsup_acc
);
    logic in_win;
    assign in_win = (io_addr >> WIN_BITS) == (BASE_ADDR >> WIN_BITS);

    // Clear-busy pulse only after a byte write to the first window port.
    assert_clr_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy_evt |-> $past(io_wr && io_addr == BASE_ADDR && io_size == 2'd0));

    // Reset pulse only after a byte write to the second window port.
    assert_rst_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cop_rst_evt |-> $past(io_wr && io_addr == BASE_ADDR + 1 && io_size == 2'd0));

    // Interrupt falls only after a byte write in the window (or reset).
    assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_err) |-> ($past(io_wr && in_win && io_size == 2'd0) || $past(!rst_n)));

    // Wide writes in the window are flagged.
    assert_wide_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && in_win && io_size != 2'd0) |=> unsup_acc);

    // Interrupt rises only when the error pin was high.
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err) |-> $past(err_in));

    // Window reads return the unused value.
    assert_rd_val_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && in_win) |=> (rd_data == '1 && unsup_acc));

    // The two command pulses never coincide.
    assert_evt_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({clr_busy_evt, cop_rst_evt}) <= 1);

endmodule

bind cop_err_port cop_err_port_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WIN_BITS (WIN_BITS),
    .BASE_ADDR(BASE_ADDR)
) i_cop_err_port_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_size     (io_size),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .err_in      (err_in),
    .rd_data     (rd_data),
    .irq_err     (irq_err),
    .clr_busy_evt(clr_busy_evt),
    .cop_rst_evt (cop_rst_evt),
    .unsup_acc   (unsup_acc)
);

// File: tb/test_cop_err_port.sv
// Directed bench for cop_err_port: one task per scenario.
module test_cop_err_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [1:0]  io_size = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic        err_in = 1'b0;
    logic [7:0]  rd_data;
    logic        irq_err;
    logic        clr_busy_evt;
    logic        cop_rst_evt;
    logic        unsup_acc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cop_err_port i_cop_err_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd), .err_in(err_in),
        .rd_data(rd_data), .irq_err(irq_err), .clr_busy_evt(clr_busy_evt),
        .cop_rst_evt(cop_rst_evt), .unsup_acc(unsup_acc)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Check all pulse outputs and the interrupt at once.
    task automatic check_outs(input string req, input logic irq, input logic clr,
                              input logic rst, input logic uns);
        check({req, " irq"}, {7'd0, irq_err}, {7'd0, irq});
        check({req, " clr"}, {7'd0, clr_busy_evt}, {7'd0, clr});
        check({req, " rst"}, {7'd0, cop_rst_evt}, {7'd0, rst});
        check({req, " unsup"}, {7'd0, unsup_acc}, {7'd0, uns});
    endtask

    // One write cycle; returns at the negedge after the sampling edge.
    task automatic io_write(input logic [15:0] a, input logic [1:0] sz);
        @(negedge clk);
        io_addr = a; io_size = sz; io_wdata = 8'h5A; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_size = 2'd0; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // Pulse the error pin high for one cycle so the latch sets.
    task automatic raise_err();
        @(negedge clk);
        err_in = 1'b1;
        @(negedge clk);
        err_in = 1'b0;
    endtask

    task automatic t_reset();
        check_outs("R10 reset", 0, 0, 0, 0);
        check("R10 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_err_set();
        raise_err();
        check("R7 err sets irq", {7'd0, irq_err}, 8'd1);
    endtask

    task automatic t_clear_busy();
        io_write(16'h00F0, 2'd0);
        check_outs("R2/R4 clear-busy", 0, 1, 0, 0);
        @(negedge clk);
        check("R2 pulse one cycle", {7'd0, clr_busy_evt}, 8'd0);
    endtask

    task automatic t_cop_reset();
        raise_err();
        io_write(16'h00F1, 2'd0);
        check_outs("R3/R4 cop reset", 0, 0, 1, 0);
        @(negedge clk);
        check("R3 pulse one cycle", {7'd0, cop_rst_evt}, 8'd0);
    endtask

    task automatic t_opcode_ports();
        foreach (opc[i]) begin
            raise_err();
            io_write(opc[i], 2'd0);
            check_outs("R5/R4 other port", 0, 0, 0, 1);
            @(negedge clk);
            check("R5 pulse one cycle", {7'd0, unsup_acc}, 8'd0);
        end
    endtask
    logic [15:0] opc [4] = '{16'h00F8, 16'h00FA, 16'h00FC, 16'h00FF};

    task automatic t_wide_write();
        raise_err();
        for (int s = 1; s < 4; s++) begin
            io_write(16'h00F0, 2'(s));
            check_outs("R6 wide write", 1, 0, 0, 1);
        end
    endtask

    task automatic t_outside();
        for (int k = 0; k < 3; k++) begin
            logic [15:0] a;
            a = (k == 0) ? 16'h00EF : (k == 1) ? 16'h0100 : 16'h01F0;
            io_write(a, 2'd0);
            check_outs("R1 outside write", 1, 0, 0, 0);
            io_read(a);
            check("R1 outside read", rd_data, 8'h00);
            check("R1 outside read flag", {7'd0, unsup_acc}, 8'd0);
        end
    endtask

    task automatic t_read();
        io_read(16'h00F3);
        check("R9 read data", rd_data, 8'hFF);
        check("R9 read flag", {7'd0, unsup_acc}, 8'd1);
        check("R9 read keeps irq", {7'd0, irq_err}, 8'd1);
        @(negedge clk);
        check("R9 read data idle", rd_data, 8'h00);
    endtask

    task automatic t_held_err();
        io_write(16'h00F0, 2'd0);
        @(negedge clk);
        err_in = 1'b1;
        @(negedge clk);
        check("R7 rise sets", {7'd0, irq_err}, 8'd1);
        io_write(16'h00F0, 2'd0);
        check("R7 held err clear", {7'd0, irq_err}, 8'd0);
        @(negedge clk);
        check("R7 held err no reset", {7'd0, irq_err}, 8'd0);
        err_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        check("R8 precondition", {7'd0, irq_err}, 8'd0);
        io_addr = 16'h00F0; io_size = 2'd0; io_wr = 1'b1; err_in = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; err_in = 1'b0;
        check_outs("R8 set wins", 1, 1, 0, 0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        io_addr = 16'h00F5; io_wr = 1'b1; io_size = 2'd0;
        rst_n = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
        check_outs("R10 mid reset", 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_err_set();
        t_clear_busy();
        t_cop_reset();
        t_opcode_ports();
        t_wide_write();
        t_outside();
        t_read();
        t_held_err();
        t_set_wins();
        t_mid_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule